// File: doc/BRIEF.md
# Maskable Interrupt Recognition Sequencer

This block sits beside the sequencing logic of a small 8-bit processor. Each cycle it decides whether a pending maskable interrupt request should take the place of the next opcode fetch. When it should, the fetch cycle is replaced by a forced break sequence. The block keeps the interrupt-mask flag. It follows the instructions that clear the flag, set the flag, or load the flag from the stack. It also follows the stall input, which freezes the processor's phase.

The mask flag changes late. A flag-changing instruction does not use its own new mask value when the request is judged in its own last cycle. A stall changes this. During a stall inside a clear-mask or set-mask instruction, the flag takes its new value early. A request that was already seen during the stall is remembered and is not lost.

The neighbouring sequencer drives the phase and the instruction class. Every pin is a plain control level, and the block has no streaming interface. The only output timing rule concerns the force strobe: it is a combinational pulse that is valid in the fetch cycle it replaces.

Top module: `irq_take_sequencer`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `mask_o` is 1 and `force_brk_o` is 0. A recognition that was pending before the reset is discarded.
- R2: The request passes through one register. A request that first goes high in a last cycle (phase code 2'b00) is not seen in that last cycle.
- R3: In a last cycle with `rdy_i` high, suppose the registered request is 1 and the mask is 0. Then `force_brk_o` is 1 in the next fetch cycle (phase code 2'b01) that has `rdy_i` high. It is 1 in that cycle only.
- R4: A clear-mask instruction (class code 2'b01) sets the mask to 0 at the end of its last cycle. The request is judged against the old mask in that same last cycle.
- R5: A set-mask instruction (class code 2'b10) sets the mask to 1 at the end of its last cycle. The request is judged against the old mask in that same last cycle.
- R6: A flag-pull instruction (class code 2'b11) loads `pulled_mask_i` into the mask at the end of its last cycle. Its own last cycle uses the old mask.
- R7: While `rdy_i` is low, `force_brk_o` stays 0. A recognition that is already pending waits for the next fetch cycle with `rdy_i` high.
- R8: During a stall cycle with class code 2'b01 or 2'b10, the mask takes that instruction's new value at the end of the stall cycle.
- R9: Suppose the registered request is 1 and the mask is 0 in a stall cycle. Then the request is recognized in the last cycle that follows the stall, even if the mask has become 1 by then. A request that only reaches the register after the stall is judged against the mask as it is then.
- R10: A stall cycle during a flag-pull instruction does not change the mask. That instruction's outcome is the same as without the stall.
- Phase codes are 2'b00 last, 2'b01 fetch, 2'b10 second and 2'b11 third. Class code 2'b00 means any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Level interrupt request |
| rdy_i | input | 1 | Low stalls the processor for this cycle |
| phase_i | input | 2 | Phase of the current cycle |
| op_class_i | input | 2 | Class of the current instruction |
| pulled_mask_i | input | 1 | Mask value loaded by a flag-pull instruction |
| mask_o | output | 1 | Current interrupt-mask flag |
| force_brk_o | output | 1 | Replace this fetch with a forced break |

## Verification
The bench goes after the timing of each flag-changing instruction. A design that let the new mask act in the instruction's own last cycle would take the interrupt one instruction early after a clear. It would also miss the interrupt after a set, and the flag-pull cases would swap their outcomes. The stall cases are checked next. If the early update during a stall were missing, the interrupt would come one instruction late after a stalled clear. Without the stall memory, the interrupt would be lost after a stalled set. A design that skipped the input register, or sampled the request unregistered during the stall, would wrongly take a request that arrives with the stall. The bench also checks that a stalled fetch holds the pulse back, that the pulse lasts one cycle, and that a reset drops a pending recognition.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  typedef enum logic [1:0] {
    PH_LAST  = 2'b00,
    PH_FETCH = 2'b01,
    PH_MID   = 2'b10,
    PH_LATE  = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    OP_OTHER      = 2'b00,
    OP_CLEAR_MASK = 2'b01,
    OP_SET_MASK   = 2'b10,
    OP_PULL_FLAGS = 2'b11
  } op_class_e;

endpackage

// File: rtl/irqseq_sync.sv
module irqseq_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic req_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= req_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign req_o = chain_q[LAST];
endmodule

// File: rtl/irqseq_mask.sv
module irqseq_mask
  import irqseq_pkg::*;
#(
  parameter bit EARLY_ON_STALL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rdy_i,
  input  phase_e    phase_i,
  input  op_class_e op_i,
  input  logic      pulled_i,
  output logic      mask_o
);
  logic mask_q;
  logic mask_d;
  logic end_of_op;
  logic early_hit;

  assign end_of_op = rdy_i && (phase_i == PH_LAST);

  // A stall during a clear or set lets the new flag value settle early;
  // a pull has no value to apply until its final cycle.
  generate
    if (EARLY_ON_STALL) begin : g_early
      assign early_hit = !rdy_i &&
                         ((op_i == OP_CLEAR_MASK) || (op_i == OP_SET_MASK));
    end else begin : g_late
      assign early_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    mask_d = mask_q;
    if (end_of_op || early_hit) begin
      unique case (op_i)
        OP_CLEAR_MASK: mask_d = 1'b0;
        OP_SET_MASK:   mask_d = 1'b1;
        OP_PULL_FLAGS: mask_d = end_of_op ? pulled_i : mask_q;
        default:       mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b1;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqseq_recog.sv
module irqseq_recog
  import irqseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rdy_i,
  input  phase_e phase_i,
  input  logic   req_s_i,
  input  logic   mask_i,
  output logic   force_o
);
  logic stall_seen_q;
  logic pend_q;
  logic unmasked;
  logic judge;
  logic take_fetch;

  assign unmasked   = req_s_i && !mask_i;
  assign judge      = rdy_i && (phase_i == PH_LAST);
  assign take_fetch = rdy_i && (phase_i == PH_FETCH);

  // Remembers a request that was unmasked during a stall, so that a flag
  // set during that stall cannot hide it from the final-cycle judgement.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stall_seen_q <= 1'b0;
    else if (!rdy_i) stall_seen_q <= stall_seen_q | unmasked;
    else             stall_seen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (judge)      pend_q <= unmasked | stall_seen_q;
    else if (take_fetch) pend_q <= 1'b0;
  end

  assign force_o = pend_q && take_fetch;
endmodule

// File: rtl/irq_take_sequencer.sv
module irq_take_sequencer
  import irqseq_pkg::*;
#(
  parameter int SYNC_STAGES    = 1,
  parameter bit EARLY_ON_STALL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req_i,
  input  logic       rdy_i,
  input  logic [1:0] phase_i,
  input  logic [1:0] op_class_i,
  input  logic       pulled_mask_i,
  output logic       mask_o,
  output logic       force_brk_o
);
  phase_e    phase;
  op_class_e op_class;
  logic      req_s;
  logic      mask;

  assign phase    = phase_e'(phase_i);
  assign op_class = op_class_e'(op_class_i);

  irqseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (irq_req_i),
    .req_o (req_s)
  );

  irqseq_mask #(.EARLY_ON_STALL(EARLY_ON_STALL)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_i    (rdy_i),
    .phase_i  (phase),
    .op_i     (op_class),
    .pulled_i (pulled_mask_i),
    .mask_o   (mask)
  );

  irqseq_recog u_recog (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_i   (rdy_i),
    .phase_i (phase),
    .req_s_i (req_s),
    .mask_i  (mask),
    .force_o (force_brk_o)
  );

  assign mask_o = mask;
endmodule

// File: rtl/irq_take_sequencer_chk.sv
module irq_take_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy_i,
  input logic [1:0] phase_i,
  input logic [1:0] op_class_i,
  input logic       pulled_mask_i,
  input logic       mask_o,
  input logic       force_brk_o
);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_brk_o |=> !force_brk_o);

  assert_no_force_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_i |-> !force_brk_o);

  assert_clear_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && phase_i == 2'b00 && op_class_i == 2'b01) |=> !mask_o);

  assert_set_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && phase_i == 2'b00 && op_class_i == 2'b10) |=> mask_o);

  assert_pull_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && phase_i == 2'b00 && op_class_i == 2'b11) |=> (mask_o == $past(pulled_mask_i)));

  assert_early_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_i && op_class_i == 2'b01) |=> !mask_o);

  assert_early_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_i && op_class_i == 2'b10) |=> mask_o);

  assert_pull_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_i && op_class_i == 2'b11) |=> $stable(mask_o));

  assert_mid_op_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && phase_i != 2'b00) |=> $stable(mask_o));
endmodule

bind irq_take_sequencer irq_take_sequencer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rdy_i         (rdy_i),
  .phase_i       (phase_i),
  .op_class_i    (op_class_i),
  .pulled_mask_i (pulled_mask_i),
  .mask_o        (mask_o),
  .force_brk_o   (force_brk_o)
);

// File: tb/irq_take_sequencer_tb.sv
module irq_take_sequencer_tb;
  localparam logic [1:0] T0 = 2'd0, T1 = 2'd1, T2 = 2'd2, T3 = 2'd3;
  localparam logic [1:0] OT = 2'd0, CL = 2'd1, SE = 2'd2, PL = 2'd3;
  localparam int NV = 60;

  function automatic logic [13:0] v(input logic rs, input logic ir, input logic ry,
                                    input logic [1:0] ph, input logic [1:0] cl,
                                    input logic pv, input logic ef, input logic em,
                                    input logic [3:0] tg);
    return {rs, ir, ry, ph, cl, pv, ef, em, tg};
  endfunction

  function automatic string req_name(input logic [3:0] tg);
    case (tg)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  // fields: reset, irq, rdy, phase, class, pulled, expected force, expected mask, req
  localparam logic [13:0] VEC [NV] = '{
    // clear then no-op: taken after the no-op
    v(1,0,1,T0,OT,0,0,1,1), v(0,0,1,T1,CL,0,0,1,4), v(0,0,1,T0,CL,0,0,1,4),
    v(0,1,1,T1,OT,0,0,0,4), v(0,1,1,T0,OT,0,0,0,3), v(0,1,1,T1,OT,0,1,0,3),
    // set, clear with request pending, no-op
    v(1,0,1,T0,OT,0,0,1,1), v(0,0,1,T1,SE,0,0,1,5), v(0,0,1,T0,SE,0,0,1,5),
    v(0,1,1,T1,CL,0,0,1,4), v(0,1,1,T0,CL,0,0,1,4), v(0,1,1,T1,OT,0,0,0,4),
    v(0,1,1,T0,OT,0,0,0,4), v(0,1,1,T1,OT,0,1,0,4),
    // clear stalled: taken right after the clear
    v(1,0,1,T0,OT,0,0,1,1), v(0,0,1,T1,SE,0,0,1,5), v(0,0,1,T0,SE,0,0,1,5),
    v(0,1,1,T1,CL,0,0,1,4), v(0,1,0,T0,CL,0,0,1,8), v(0,1,1,T0,CL,0,0,0,8),
    v(0,1,1,T1,OT,0,1,0,8),
    // set with request pending: taken right after the set
    v(1,0,1,T0,OT,0,0,1,1), v(0,0,1,T1,CL,0,0,1,4), v(0,0,1,T0,CL,0,0,1,4),
    v(0,1,1,T1,SE,0,0,0,5), v(0,1,1,T0,SE,0,0,0,5), v(0,1,1,T1,OT,0,1,1,5),
    // set stalled, request pending before the stall
    v(1,0,1,T0,OT,0,0,1,1), v(0,0,1,T1,CL,0,0,1,4), v(0,0,1,T0,CL,0,0,1,4),
    v(0,1,1,T1,SE,0,0,0,5), v(0,1,0,T0,SE,0,0,0,7), v(0,1,1,T0,SE,0,0,1,8),
    v(0,1,1,T1,OT,0,1,1,9),
    // set stalled, request arrives with the stall: never taken
    v(1,0,1,T0,OT,0,0,1,1), v(0,0,1,T1,CL,0,0,1,4), v(0,0,1,T0,CL,0,0,1,4),
    v(0,0,1,T1,SE,0,0,0,5), v(0,1,0,T0,SE,0,0,0,7), v(0,1,1,T0,SE,0,0,1,9),
    v(0,1,1,T1,OT,0,0,1,9), v(0,1,1,T0,OT,0,0,1,5), v(0,1,1,T1,OT,0,0,1,5),
    // pull 0 over mask 1: taken after the following no-op
    v(1,0,1,T0,OT,0,0,1,1), v(0,1,1,T1,PL,0,0,1,6), v(0,1,1,T2,PL,0,0,1,6),
    v(0,1,1,T3,PL,0,0,1,6), v(0,1,1,T0,PL,0,0,1,6), v(0,1,1,T1,OT,0,0,0,6),
    v(0,1,1,T0,OT,0,0,0,6), v(0,1,1,T1,OT,0,1,0,6),
    // same with a stall in the third cycle
    v(1,0,1,T0,OT,0,0,1,1), v(0,1,1,T1,PL,0,0,1,6), v(0,1,1,T2,PL,0,0,1,6),
    v(0,1,1,T3,PL,0,0,1,6), v(0,1,0,T0,PL,0,0,1,10), v(0,1,1,T0,PL,0,0,1,10),
    v(0,1,1,T1,OT,0,0,0,10), v(0,1,1,T0,OT,0,0,0,10), v(0,1,1,T1,OT,0,1,0,10)
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_req;
  logic       rdy;
  logic [1:0] phase;
  logic [1:0] op_class;
  logic       pulled;
  logic       mask;
  logic       force_brk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_take_sequencer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_req_i     (irq_req),
    .rdy_i         (rdy),
    .phase_i       (phase),
    .op_class_i    (op_class),
    .pulled_mask_i (pulled),
    .mask_o        (mask),
    .force_brk_o   (force_brk)
  );

  task automatic step(input logic rs, input logic ir, input logic ry,
                      input logic [1:0] ph, input logic [1:0] cl,
                      input logic pv, input logic ef, input logic em,
                      input logic [3:0] tg);
    @(negedge clk);
    rst_n = !rs; irq_req = ir; rdy = ry; phase = ph; op_class = cl; pulled = pv;
    #2;
    n_checks++;
    if (force_brk !== ef || mask !== em) begin
      n_fails++;
      $display("FAIL %s: force=%b mask=%b expected force=%b mask=%b at %0t",
               req_name(tg), force_brk, mask, ef, em, $time);
    end
  endtask

  initial begin
    rst_n = 1'b0; irq_req = 1'b0; rdy = 1'b1; phase = T0; op_class = OT; pulled = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [13:0] e;
      e = VEC[i];
      step(e[13], e[12], e[11], e[10:9], e[8:7], e[6], e[5], e[4], e[3:0]);
    end

    // pull 1 over mask 0: taken right after the pull
    step(1,0,1,T0,OT,0,0,1,1); step(0,0,1,T1,CL,0,0,1,4); step(0,0,1,T0,CL,0,0,1,4);
    step(0,1,1,T1,PL,1,0,0,6); step(0,1,1,T2,PL,1,0,0,6); step(0,1,1,T3,PL,1,0,0,6);
    step(0,1,1,T0,PL,1,0,0,6); step(0,1,1,T1,OT,0,1,1,6);

    // same with a stall in the third cycle
    step(1,0,1,T0,OT,0,0,1,1); step(0,0,1,T1,CL,0,0,1,4); step(0,0,1,T0,CL,0,0,1,4);
    step(0,1,1,T1,PL,1,0,0,6); step(0,1,1,T2,PL,1,0,0,6); step(0,1,1,T3,PL,1,0,0,6);
    step(0,1,0,T0,PL,1,0,0,10); step(0,1,1,T0,PL,1,0,0,10); step(0,1,1,T1,OT,0,1,1,10);

    // request raised only in the last cycle is seen one instruction later
    step(1,0,1,T0,OT,0,0,1,1); step(0,0,1,T1,CL,0,0,1,4); step(0,0,1,T0,CL,0,0,1,4);
    step(0,0,1,T1,OT,0,0,0,2); step(0,1,1,T0,OT,0,0,0,2); step(0,1,1,T1,OT,0,0,0,2);
    step(0,1,1,T0,OT,0,0,0,2); step(0,1,1,T1,OT,0,1,0,2);

    // stalled fetch holds the pulse back; the pulse is single
    step(1,0,1,T0,OT,0,0,1,1); step(0,0,1,T1,CL,0,0,1,4); step(0,0,1,T0,CL,0,0,1,4);
    step(0,1,1,T1,OT,0,0,0,3); step(0,1,1,T0,OT,0,0,0,3);
    step(0,1,0,T1,OT,0,0,0,7); step(0,1,0,T1,OT,0,0,0,7);
    step(0,0,1,T1,OT,0,1,0,7); step(0,0,1,T0,OT,0,0,0,3); step(0,0,1,T1,OT,0,0,0,3);

    // reset drops a pending recognition
    step(1,0,1,T0,OT,0,0,1,1); step(0,0,1,T1,CL,0,0,1,4); step(0,0,1,T0,CL,0,0,1,4);
    step(0,1,1,T1,OT,0,0,0,3); step(0,1,1,T0,OT,0,0,0,3);
    step(1,1,1,T1,OT,0,0,1,1); step(0,1,1,T1,OT,0,0,1,1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1: watchdog expired, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule